// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital sequencer that sits between a configuration interface and an analog converter core. It steps through a programmed channel list of up to eight slots and picks one of fourteen multiplexed inputs for each slot. For each slot it pulses a start to the converter and waits for the converter's done strobe. It then stores the returned sample in the data register that belongs to that slot.

A group runs when a trigger arrives from one of three sources: a software pulse, an external event or a timer event. An enable mask chooses which sources count. Three run modes are available:

- **One-shot:** the whole group runs once per trigger.
- **Continuous:** the group repeats without further triggers.
- **Discontinuous:** each trigger converts a single slot and moves the position on by one.

Two raw flags report progress. One marks every finished sample and the other marks every finished group. Each flag can be cleared by a write-one strobe and can be masked onto a single interrupt line. Writing the configuration while a group is running aborts the group. After an abort, nothing runs until a new trigger arrives.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `conv_start`, both flags and `irq` are 0, and every result register reads 0.
- R2: In one-shot mode (`cfg_mode` = 0, and also for the reserved code 3), one accepted trigger issues a start for slots 0, 1, … up to the last slot. Each start drives `conv_ch` with the channel code held in `cfg_list[4i+3:4i]` for slot i. After the last slot the block returns to idle and issues no further starts.
- R3: A length field value N gives exactly N+1 conversions per group. The value 0 gives a single conversion.
- R4: In continuous mode (`cfg_mode` = 1), the sequence restarts at slot 0 after the last slot with no new trigger. It keeps running until a configuration write.
- R5: In discontinuous mode (`cfg_mode` = 2), each trigger converts exactly one slot and then returns to idle. The position wraps to slot 0 after the last slot, and any configuration write resets the position to slot 0.
- R6: A configuration write (`cfg_we`) while busy aborts the group. No further start follows. A done strobe still in flight is neither stored nor flagged. Only a new trigger starts a new group.
- R7: A sample returned for slot i is stored in `res_data[16i+15:16i]`. Registers of slots that were not converted keep their value.
- R8: `cfg_trig_sel` bit 0 enables the software trigger, bit 1 the external trigger and bit 2 the timer trigger. Pulses on sources that are not enabled start nothing.
- R9: Triggers that arrive while a group (or a discontinuous slot) is in progress are dropped. They neither extend nor restart the sequence.
- R10: While the converter is disabled, triggers are ignored. After any change of `cfg_enable`, triggers are ignored for the next 2 clock cycles.
- R11: `flag_sample` is set when each conversion completes, and `flag_group` is set when the last slot of a group completes. `flag_clr` bit 0 clears `flag_sample` and bit 1 clears `flag_group`. A set in the same cycle wins over a clear.
- R12: `irq` is high exactly when (`flag_sample` AND `irq_en[0]`) OR (`flag_group` AND `irq_en[1]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe; loads the cfg_* fields below |
| cfg_enable | input | 1 | Converter enable |
| cfg_mode | input | 2 | 0 one-shot, 1 continuous, 2 discontinuous, 3 as one-shot |
| cfg_len | input | 3 | Group length minus one |
| cfg_list | input | 32 | Channel code per slot, slot i at bits [4i+3:4i] |
| cfg_trig_sel | input | 3 | Trigger source enables: software, external, timer |
| irq_en | input | 2 | Interrupt enables: bit 0 sample, bit 1 group |
| sw_trig | input | 1 | Software trigger pulse |
| ext_trig | input | 1 | External event trigger pulse |
| tmr_trig | input | 1 | Timer event trigger pulse |
| conv_start | output | 1 | One-cycle start to the converter core |
| conv_ch | output | 4 | Channel select for the converter core |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 16 | Converter sample, valid with conv_done |
| res_data | output | 128 | Result registers, slot i at bits [16i+15:16i] |
| flag_sample | output | 1 | Raw per-sample end-of-conversion flag |
| flag_group | output | 1 | Raw per-group end-of-conversion flag |
| flag_clr | input | 2 | Write-one-to-clear strobes for the flags |
| irq | output | 1 | Masked interrupt |
| busy | output | 1 | A conversion group or slot is in progress |

## Verification
The bench builds the block with its default parameters: 14 channels, 8 slots, 16-bit samples and a 2-cycle enable settle window. With 8 slots, a full-length group walks every slot and the highest slot index. The length code also reaches its all-ones value, so the last-slot compare and the discontinuous wrap are both exercised at their extremes. Channel 13 is reachable as the topmost code. Because the settle window is 2 cycles, the bench can test trigger pulses on the exact cycles just inside and just outside it.

// File: rtl/adc_seq_pkg.sv
// Shared types for the conversion sequence controller.
// Assumes: mode code 3 is reserved and is handled like one-shot.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'd0,
        MODE_CONT    = 2'd1,
        MODE_DISC    = 2'd2,
        MODE_RSVD    = 2'd3
    } seq_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_trig_gate.sv
// Trigger gate: merges the three trigger sources under their enable mask and
// blocks them while the converter is disabled or still settling after an
// enable change.
// Assumes: en_i is the registered enable, and en_changed_i pulses in the cycle
// that the enable register is loaded with a new value.
module adc_trig_gate #(
    parameter int WARMUP = 2,
    localparam int CNT_W = $clog2(WARMUP + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       en_changed_i,
    input  logic [2:0] sel_i,
    input  logic       sw_i,
    input  logic       ext_i,
    input  logic       tmr_i,
    output logic       trig_o
);

    logic [CNT_W-1:0] settle_q;

    // Settle counter: reload on an enable change, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            settle_q <= '0;
        else if (en_changed_i)
            settle_q <= CNT_W'(WARMUP);
        else if (settle_q != '0)
            settle_q <= settle_q - 1'b1;
    end

    // Accepted trigger: any enabled source, converter on and settled.
    always_comb begin
        trig_o = en_i && (settle_q == '0) && (|(sel_i & {tmr_i, ext_i, sw_i}));
    end

    // R10: no trigger passes in the cycle right after an enable change.
    a_r10_settle_block: assert property (@(posedge clk) disable iff (!rst_n)
        en_changed_i |=> !trig_o);

endmodule

// File: rtl/adc_seq_fsm.sv
// Sequencer: walks the channel list slot by slot, handshakes with the
// converter core and applies the mode-dependent restart rules.
// Assumes: configuration inputs change only together with cfg_write_i, so a
// change always aborts a running group.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int MAX_SLOTS = 8,
    parameter int CH_W      = 4,
    localparam int SLOT_W   = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trig_i,
    input  logic                      cfg_write_i,
    input  seq_mode_e                 mode_i,
    input  logic [SLOT_W-1:0]         len_i,
    input  logic [MAX_SLOTS*CH_W-1:0] list_i,
    input  logic                      conv_done_i,
    output logic                      conv_start_o,
    output logic [CH_W-1:0]           conv_ch_o,
    output logic                      busy_o,
    output logic                      wr_en_o,
    output logic [SLOT_W-1:0]         wr_slot_o,
    output logic                      sample_eoc_o,
    output logic                      group_eoc_o
);

    seq_state_e        state_q;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] disc_pos_q;
    logic              last_slot;
    logic              done_ok;

    // Handshake decode: current slot, last-slot test, accepted completion.
    always_comb begin
        last_slot    = (slot_q == len_i);
        done_ok      = (state_q == ST_WAIT) && conv_done_i && !cfg_write_i;
        conv_start_o = (state_q == ST_START);
        conv_ch_o    = list_i[slot_q*CH_W +: CH_W];
        busy_o       = (state_q != ST_IDLE);
        wr_en_o      = done_ok;
        wr_slot_o    = slot_q;
        sample_eoc_o = done_ok;
        group_eoc_o  = done_ok && last_slot;
    end

    // State, slot and discontinuous-position update; a config write aborts.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_write_i) begin
            state_q    <= ST_IDLE;
            slot_q     <= '0;
            disc_pos_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (trig_i) begin
                        slot_q  <= (mode_i == MODE_DISC) ? disc_pos_q : '0;
                        state_q <= ST_START;
                    end
                end
                ST_START: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (conv_done_i) begin
                        if (mode_i == MODE_DISC) begin
                            disc_pos_q <= last_slot ? '0 : slot_q + 1'b1;
                            state_q    <= ST_IDLE;
                        end else if (!last_slot) begin
                            slot_q  <= slot_q + 1'b1;
                            state_q <= ST_START;
                        end else if (mode_i == MODE_CONT) begin
                            slot_q  <= '0;
                            state_q <= ST_START;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: a start to the converter lasts exactly one cycle.
    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    // R6: a configuration write leaves the sequencer idle.
    a_r6_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_write_i |=> !busy_o);

    // R9: while waiting, nothing but done or a config write moves the slot.
    a_r9_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !conv_done_i && !cfg_write_i)
        |=> (state_q == ST_WAIT && $stable(slot_q)));

    // R3: a running slot never passes the programmed length.
    a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (slot_q <= len_i));

endmodule

// File: rtl/adc_result_bank.sv
// Result bank: one data register per slot, written when the converter
// reports completion for that slot.
// Assumes: at most one write per cycle.
module adc_result_bank #(
    parameter int MAX_SLOTS = 8,
    parameter int DATA_W    = 16,
    localparam int SLOT_W   = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [SLOT_W-1:0]           wr_slot_i,
    input  logic [DATA_W-1:0]           data_i,
    output logic [MAX_SLOTS*DATA_W-1:0] res_o
);

    for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] val_q;

        // Slot register: capture the sample addressed to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= '0;
            else if (wr_en_i && wr_slot_i == SLOT_W'(g))
                val_q <= data_i;
        end

        assign res_o[g*DATA_W +: DATA_W] = val_q;

        // R7: a write addressed here appears in this slot on the next cycle.
        a_r7_slot_store: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_slot_i == SLOT_W'(g)) |=> (val_q == $past(data_i)));
    end

endmodule

// File: rtl/adc_flag_irq.sv
// Flag and interrupt logic: raw sample and group flags with write-one clear,
// and a masked interrupt.
// Assumes: a set and a clear in the same cycle leave the flag set.
module adc_flag_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_eoc_i,
    input  logic       group_eoc_i,
    input  logic [1:0] clr_i,
    input  logic [1:0] ie_i,
    output logic       flag_sample_o,
    output logic       flag_group_o,
    output logic       irq_o
);

    // Raw flags: set on events, clear on strobe, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_sample_o <= 1'b0;
            flag_group_o  <= 1'b0;
        end else begin
            flag_sample_o <= sample_eoc_i | (flag_sample_o & ~clr_i[0]);
            flag_group_o  <= group_eoc_i  | (flag_group_o  & ~clr_i[1]);
        end
    end

    // Interrupt: each raw flag gated by its enable bit.
    always_comb begin
        irq_o = (flag_sample_o & ie_i[0]) | (flag_group_o & ie_i[1]);
    end

    // R11: every completed sample leaves the sample flag set.
    a_r11_sample_set: assert property (@(posedge clk) disable iff (!rst_n)
        sample_eoc_i |=> flag_sample_o);

    // R11: a group end is always also a sample end.
    a_r11_group_in_sample: assert property (@(posedge clk) disable iff (!rst_n)
        group_eoc_i |-> sample_eoc_i);

    // R12: with both enables off the interrupt stays low.
    a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_i == 2'b00) |-> !irq_o);

endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the conversion sequence controller: holds the configuration
// registers and connects the trigger gate, sequencer, result bank and flags.
// Assumes: the converter core answers each start with one done pulse that
// carries its sample; configuration is loaded only through cfg_we.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH    = 14,
    parameter int MAX_SLOTS = 8,
    parameter int DATA_W    = 16,
    parameter int WARMUP    = 2,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int SLOT_W   = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic                        cfg_enable,
    input  logic [1:0]                  cfg_mode,
    input  logic [SLOT_W-1:0]           cfg_len,
    input  logic [MAX_SLOTS*CH_W-1:0]   cfg_list,
    input  logic [2:0]                  cfg_trig_sel,
    input  logic [1:0]                  irq_en,
    input  logic                        sw_trig,
    input  logic                        ext_trig,
    input  logic                        tmr_trig,
    output logic                        conv_start,
    output logic [CH_W-1:0]             conv_ch,
    input  logic                        conv_done,
    input  logic [DATA_W-1:0]           conv_data,
    output logic [MAX_SLOTS*DATA_W-1:0] res_data,
    output logic                        flag_sample,
    output logic                        flag_group,
    input  logic [1:0]                  flag_clr,
    output logic                        irq,
    output logic                        busy
);

    logic                      en_q;
    seq_mode_e                 mode_q;
    logic [SLOT_W-1:0]         len_q;
    logic [MAX_SLOTS*CH_W-1:0] list_q;
    logic [2:0]                sel_q;
    logic                      en_changed;
    logic                      trig_ok;
    logic                      wr_en;
    logic [SLOT_W-1:0]         wr_slot;
    logic                      sample_eoc;
    logic                      group_eoc;

    // Enable-change detect for the settle window.
    always_comb begin
        en_changed = cfg_we && (cfg_enable != en_q);
    end

    // Configuration registers, loaded by the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= MODE_ONESHOT;
            len_q  <= '0;
            list_q <= '0;
            sel_q  <= '0;
        end else if (cfg_we) begin
            en_q   <= cfg_enable;
            mode_q <= seq_mode_e'(cfg_mode);
            len_q  <= cfg_len;
            list_q <= cfg_list;
            sel_q  <= cfg_trig_sel;
        end
    end

    adc_trig_gate #(.WARMUP(WARMUP)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_q),
        .en_changed_i (en_changed),
        .sel_i        (sel_q),
        .sw_i         (sw_trig),
        .ext_i        (ext_trig),
        .tmr_i        (tmr_trig),
        .trig_o       (trig_ok)
    );

    adc_seq_fsm #(.MAX_SLOTS(MAX_SLOTS), .CH_W(CH_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig_ok),
        .cfg_write_i  (cfg_we),
        .mode_i       (mode_q),
        .len_i        (len_q),
        .list_i       (list_q),
        .conv_done_i  (conv_done),
        .conv_start_o (conv_start),
        .conv_ch_o    (conv_ch),
        .busy_o       (busy),
        .wr_en_o      (wr_en),
        .wr_slot_o    (wr_slot),
        .sample_eoc_o (sample_eoc),
        .group_eoc_o  (group_eoc)
    );

    adc_result_bank #(.MAX_SLOTS(MAX_SLOTS), .DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_slot_i (wr_slot),
        .data_i    (conv_data),
        .res_o     (res_data)
    );

    adc_flag_irq u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_eoc_i  (sample_eoc),
        .group_eoc_i   (group_eoc),
        .clr_i         (flag_clr),
        .ie_i          (irq_en),
        .flag_sample_o (flag_sample),
        .flag_group_o  (flag_group),
        .irq_o         (irq)
    );

    // R10: while disabled, no start is ever issued from idle.
    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !busy) |=> !conv_start);

    // R6: a config write is never followed directly by a start.
    a_r6_no_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !conv_start);

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic         cfg_enable = 1'b0;
    logic [1:0]   cfg_mode = 2'd0;
    logic [2:0]   cfg_len = 3'd0;
    logic [31:0]  cfg_list = 32'd0;
    logic [2:0]   cfg_trig_sel = 3'd0;
    logic [1:0]   irq_en = 2'd0;
    logic         sw_trig = 1'b0;
    logic         ext_trig = 1'b0;
    logic         tmr_trig = 1'b0;
    logic         conv_start;
    logic [3:0]   conv_ch;
    logic         conv_done = 1'b0;
    logic [15:0]  conv_data = 16'd0;
    logic [127:0] res_data;
    logic         flag_sample;
    logic         flag_group;
    logic [1:0]   flag_clr = 2'd0;
    logic         irq;
    logic         busy;

    int n_chk = 0;
    int n_err = 0;
    int n_start = 0;
    logic [3:0] log_ch [0:255];
    bit finished = 0;

    always #5 clk = ~clk;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
        .cfg_mode(cfg_mode), .cfg_len(cfg_len), .cfg_list(cfg_list),
        .cfg_trig_sel(cfg_trig_sel), .irq_en(irq_en), .sw_trig(sw_trig),
        .ext_trig(ext_trig), .tmr_trig(tmr_trig), .conv_start(conv_start),
        .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data),
        .res_data(res_data), .flag_sample(flag_sample), .flag_group(flag_group),
        .flag_clr(flag_clr), .irq(irq), .busy(busy)
    );

    // Converter model: logs each start and answers three cycles later.
    initial begin
        int pend = 0;
        logic [15:0] pdata = 16'd0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (pend != 0) begin
                pend--;
                if (pend == 0) begin
                    conv_done = 1'b1;
                    conv_data = pdata;
                end
            end
            if (conv_start) begin
                log_ch[n_start[7:0]] = conv_ch;
                pdata = {n_start[7:0], 4'h0, conv_ch};
                pend = 3;
                n_start++;
            end
        end
    end

    function automatic logic [15:0] exp_sample(input int n, input logic [3:0] ch);
        return {n[7:0], 4'h0, ch};
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic en, input logic [1:0] mode, input logic [2:0] len,
                             input logic [31:0] list, input logic [2:0] sel);
        cfg_enable = en; cfg_mode = mode; cfg_len = len; cfg_list = list; cfg_trig_sel = sel;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // which: 0 software, 1 external, 2 timer
    task automatic pulse(input int which, input int cycles);
        if (which == 0) sw_trig = 1'b1;
        else if (which == 1) ext_trig = 1'b1;
        else tmr_trig = 1'b1;
        tick(cycles);
        sw_trig = 1'b0; ext_trig = 1'b0; tmr_trig = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (busy && t < 1000) begin
            @(negedge clk);
            t++;
        end
        chk(req, "idle timeout", t >= 1000, 0);
    endtask

    task automatic clear_flags();
        flag_clr = 2'b11;
        tick(1);
        flag_clr = 2'b00;
        tick(1);
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "conv_start", conv_start, 0);
        chk("R1", "flag_sample", flag_sample, 0);
        chk("R1", "flag_group", flag_group, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "res_data", |res_data, 0);
    endtask

    task automatic t_oneshot_full();
        logic [31:0] lst = 32'h10365742;
        int base;
        write_cfg(1'b1, 2'd0, 3'd7, lst, 3'b001);
        tick(3);
        base = n_start;
        pulse(0, 1);
        wait_idle("R2");
        chk("R3", "starts len 7", n_start - base, 8);
        for (int i = 0; i < 8; i++) begin
            chk("R2", "slot channel", log_ch[(base + i) % 256], lst[i*4 +: 4]);
            chk("R7", "slot result", res_data[i*16 +: 16], exp_sample(base + i, lst[i*4 +: 4]));
        end
        tick(2);
        chk("R11", "sample flag", flag_sample, 1);
        chk("R11", "group flag", flag_group, 1);
        tick(10);
        chk("R2", "no start after group", n_start - base, 8);
        chk("R2", "idle after group", busy, 0);
    endtask

    task automatic t_len_one();
        int base;
        logic [15:0] keep1 = res_data[31:16];
        clear_flags();
        chk("R11", "clear sample", flag_sample, 0);
        chk("R11", "clear group", flag_group, 0);
        write_cfg(1'b1, 2'd3, 3'd0, 32'h0000000D, 3'b001);
        base = n_start;
        pulse(0, 1);
        wait_idle("R3");
        tick(2);
        chk("R3", "single start", n_start - base, 1);
        chk("R2", "channel 13", log_ch[base % 256], 13);
        chk("R7", "slot0", res_data[15:0], exp_sample(base, 4'd13));
        chk("R7", "slot1 untouched", res_data[31:16], keep1);
        chk("R11", "group after one", flag_group, 1);
    endtask

    task automatic t_continuous();
        int base;
        int t = 0;
        write_cfg(1'b1, 2'd1, 3'd1, 32'h000000B9, 3'b001);
        base = n_start;
        pulse(0, 1);
        while (n_start - base < 5 && t < 1000) begin tick(1); t++; end
        write_cfg(1'b1, 2'd0, 3'd1, 32'h000000B9, 3'b001);
        tick(12);
        chk("R4", "restarts seen", n_start - base, 5);
        for (int i = 0; i < 5; i++)
            chk("R4", "cont channel", log_ch[(base + i) % 256], (i % 2 == 0) ? 9 : 11);
        chk("R6", "stopped by write", busy, 0);
    endtask

    task automatic t_abort();
        int base;
        logic [15:0] keep0;
        write_cfg(1'b1, 2'd0, 3'd3, 32'h00003210, 3'b001);
        clear_flags();
        keep0 = res_data[15:0];
        base = n_start;
        pulse(0, 1);
        write_cfg(1'b1, 2'd0, 3'd3, 32'h00003210, 3'b001);
        tick(10);
        chk("R6", "one start only", n_start - base, 1);
        chk("R6", "idle after abort", busy, 0);
        chk("R6", "late done not stored", res_data[15:0], keep0);
        chk("R6", "late done not flagged", flag_sample, 0);
        base = n_start;
        pulse(0, 1);
        wait_idle("R6");
        chk("R6", "new trigger runs group", n_start - base, 4);
    endtask

    task automatic t_disc();
        int base;
        logic [31:0] lst = 32'h00000C85;
        write_cfg(1'b1, 2'd2, 3'd2, lst, 3'b001);
        clear_flags();
        base = n_start;
        for (int k = 0; k < 4; k++) begin
            pulse(0, 1);
            wait_idle("R5");
            tick(2);
            chk("R5", "one slot per trigger", n_start - base, k + 1);
            chk("R5", "disc channel", log_ch[(base + k) % 256], lst[(k % 3)*4 +: 4]);
            if (k == 0) chk("R11", "no group mid-way", flag_group, 0);
            if (k == 2) chk("R11", "group at last slot", flag_group, 1);
        end
        pulse(0, 1);
        wait_idle("R5");
        write_cfg(1'b1, 2'd2, 3'd2, lst, 3'b001);
        base = n_start;
        pulse(0, 1);
        wait_idle("R5");
        chk("R5", "position reset by write", log_ch[base % 256], 5);
    endtask

    task automatic t_sources();
        int base;
        write_cfg(1'b1, 2'd0, 3'd0, 32'h00000007, 3'b010);
        base = n_start;
        pulse(0, 1);
        tick(6);
        pulse(2, 1);
        tick(6);
        chk("R8", "sw and timer masked", n_start - base, 0);
        pulse(1, 1);
        wait_idle("R8");
        chk("R8", "external accepted", n_start - base, 1);
        write_cfg(1'b1, 2'd0, 3'd0, 32'h00000007, 3'b100);
        pulse(2, 1);
        wait_idle("R8");
        chk("R8", "timer accepted", n_start - base, 2);
    endtask

    task automatic t_busy_drop();
        int base;
        write_cfg(1'b1, 2'd0, 3'd3, 32'h00004321, 3'b001);
        base = n_start;
        pulse(0, 1);
        for (int k = 0; k < 3; k++) begin
            tick(4);
            pulse(0, 1);
        end
        wait_idle("R9");
        tick(10);
        chk("R9", "busy triggers dropped", n_start - base, 4);
        chk("R9", "stays idle", busy, 0);
    endtask

    task automatic t_warmup();
        int base;
        write_cfg(1'b0, 2'd0, 3'd0, 32'h00000006, 3'b001);
        tick(4);
        base = n_start;
        pulse(0, 1);
        tick(6);
        chk("R10", "disabled ignores trigger", n_start - base, 0);
        write_cfg(1'b1, 2'd0, 3'd0, 32'h00000006, 3'b001);
        pulse(0, 2);
        tick(6);
        chk("R10", "settle window ignores", n_start - base, 0);
        write_cfg(1'b0, 2'd0, 3'd0, 32'h00000006, 3'b001);
        write_cfg(1'b1, 2'd0, 3'd0, 32'h00000006, 3'b001);
        pulse(0, 3);
        wait_idle("R10");
        chk("R10", "first cycle after window", n_start - base, 1);
    endtask

    task automatic t_irq();
        write_cfg(1'b1, 2'd0, 3'd0, 32'h00000003, 3'b001);
        irq_en = 2'b00;
        pulse(0, 1);
        wait_idle("R12");
        tick(2);
        chk("R12", "masked irq", irq, 0);
        irq_en = 2'b10;
        tick(1);
        chk("R12", "group irq", irq, 1);
        flag_clr = 2'b10;
        tick(1);
        flag_clr = 2'b00;
        tick(1);
        chk("R11", "group cleared", flag_group, 0);
        chk("R11", "sample kept", flag_sample, 1);
        chk("R12", "irq after group clear", irq, 0);
        irq_en = 2'b01;
        tick(1);
        chk("R12", "sample irq", irq, 1);
        flag_clr = 2'b01;
        tick(1);
        flag_clr = 2'b00;
        tick(1);
        chk("R12", "irq after sample clear", irq, 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_oneshot_full();
        t_len_one();
        t_continuous();
        t_abort();
        t_disc();
        t_sources();
        t_busy_drop();
        t_warmup();
        t_irq();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule